// File: doc/BRIEF.md
# Ternary Threshold Reflex Detector

This block watches a 3x3 field of nine balanced-ternary symbols, each worth -1, 0 or +1, delivered by an upstream light detector. For each sample marked valid, it makes a single reflex decision and raises a flee output. There are two decision rules. The first counts the symbols that sit at -1 and fires when that count reaches a count threshold. The second adds all nine symbols as signed values and fires when the total falls below a signed bound.

Both limits are held in writable registers rather than wired in, so a learning mechanism elsewhere can move them while the block is running. The decision comes out of a register one clock after the sample. It carries its own valid, the raw negative count, the signed sum, and a flag for any malformed symbol code.

Top module: `trit_flee_detector`

## Requirements
- R1: Symbol k occupies bits [2k+1:2k] of `sampleTrits`. The encodings are 2'b11 = -1, 2'b00 = 0 and 2'b01 = +1.
- R2: The code 2'b10 is illegal. It is counted as 0 in both the count and the sum, and `badCode` is 1 in the result for that sample.
- R3: `negCount` is the number of symbols equal to -1 (0 to 9), as a 4-bit unsigned value.
- R4: `trSum` is the signed sum of the nine symbols, as a 5-bit two's complement value (-9 to +9).
- R5: With `modeSum` = 0, `flee` is 1 exactly when `negCount` is greater than or equal to the count threshold. The count threshold resets to 7.
- R6: With `modeSum` = 1, `flee` is 1 exactly when `trSum` is strictly less than the signed sum bound. The sum bound resets to -5.
- R7: A sample taken at a rising edge with `sampleValid` = 1 sets `fleeValid` = 1 for the following cycle only. While no sample is taken, every result output keeps its value.
- R8: A write with `thrWrEn` = 1 is taken at the clock edge. `thrWrSel` = 0 loads the count threshold from `thrWrData[3:0]`, and `thrWrSel` = 1 loads the sum bound from all 5 bits as signed. A sample taken at that same edge still uses the old value; later samples use the new one.
- R9: `modeSum` is taken together with each sample. Changing it between samples leaves an already produced result unchanged.
- R10: After reset, `fleeValid`, `flee`, `negCount`, `trSum` and `badCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleTrits` and `modeSum` |
| sampleTrits | input | 18 | Nine 2-bit symbol codes |
| modeSum | input | 1 | 0 = count rule, 1 = signed-sum rule |
| thrWrEn | input | 1 | Limit register write strobe |
| thrWrSel | input | 1 | 0 = count threshold, 1 = sum bound |
| thrWrData | input | 5 | Value to write |
| fleeValid | output | 1 | Result valid, one cycle per sample |
| flee | output | 1 | Reflex decision |
| negCount | output | 4 | Number of -1 symbols in the sample |
| trSum | output | 5 | Signed symbol sum |
| badCode | output | 1 | Sample contained code 2'b10 |

## Verification
The assertions assume that `rstN` is applied for at least one edge before any sample. They also assume that every symbol code is one of the four 2-bit values, which holds for any vector, so the range properties on the count and the sum never depend on how well the upstream source behaves. The stimulus changes inputs only on falling edges and keeps samples at least one idle cycle apart. This lets the hold-while-idle property be observed between results. It walks every legal 9-symbol pattern under both rules, and it injects illegal codes only in directed cases.

// File: rtl/trit_flee_pkg.sv
package trit_flee_pkg;

  // Strobes from control to datapath, all for the current edge
  typedef struct packed {
    logic capture;   // take the sample into the result registers
    logic useSum;    // decision rule for this sample
    logic loadCnt;   // update count threshold
    logic loadSum;   // update sum bound
  } flee_strobe_t;

  localparam logic [1:0] TRIT_NEG = 2'b11;
  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_POS = 2'b01;
  localparam logic [1:0] TRIT_BAD = 2'b10;

endpackage

// File: rtl/trit_flee_ctrl.sv
module trit_flee_ctrl
  import trit_flee_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         modeSum,
  input  logic         thrWrEn,
  input  logic         thrWrSel,
  output flee_strobe_t strobe,
  output logic         outValid
);

  always_comb begin
    strobe.capture = sampleValid;
    strobe.useSum  = modeSum;
    strobe.loadCnt = thrWrEn & ~thrWrSel;
    strobe.loadSum = thrWrEn & thrWrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sampleValid;
  end

  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid); // R7
  AST_VALID_ONLY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid); // R7

endmodule

// File: rtl/trit_flee_dp.sv
module trit_flee_dp
  import trit_flee_pkg::*;
#(
  parameter int NUM_TRITS   = 9,
  parameter int CNT_W       = $clog2(NUM_TRITS + 1),
  parameter int SUM_W       = CNT_W + 1,
  parameter int CNT_THR_RST = 7,
  parameter int SUM_THR_RST = -5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  flee_strobe_t            strobe,
  input  logic [2*NUM_TRITS-1:0]  sampleTrits,
  input  logic [SUM_W-1:0]        thrWrData,
  output logic                    fleeQ,
  output logic [CNT_W-1:0]        negCountQ,
  output logic signed [SUM_W-1:0] sumQ,
  output logic                    badQ
);

  logic [NUM_TRITS-1:0] isNeg;
  logic [NUM_TRITS-1:0] isPos;
  logic [NUM_TRITS-1:0] isBad;

  // Per-symbol decode
  for (genvar k = 0; k < NUM_TRITS; k++) begin : g_decode
    logic [1:0] code;
    assign code     = sampleTrits[2*k +: 2];
    assign isNeg[k] = (code == TRIT_NEG);
    assign isPos[k] = (code == TRIT_POS);
    assign isBad[k] = (code == TRIT_BAD);
  end

  logic [CNT_W-1:0] negNow;
  logic [CNT_W-1:0] posNow;

  always_comb begin
    negNow = '0;
    posNow = '0;
    for (int k = 0; k < NUM_TRITS; k++) begin
      negNow = negNow + CNT_W'(isNeg[k]);
      posNow = posNow + CNT_W'(isPos[k]);
    end
  end

  logic signed [SUM_W-1:0] sumNow;
  assign sumNow = $signed({1'b0, posNow}) - $signed({1'b0, negNow});

  // Adjustable limits
  logic [CNT_W-1:0]        cntThr;
  logic signed [SUM_W-1:0] sumThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntThr <= CNT_W'(CNT_THR_RST);
      sumThr <= SUM_W'(SUM_THR_RST);
    end else begin
      if (strobe.loadCnt) cntThr <= thrWrData[CNT_W-1:0];
      if (strobe.loadSum) sumThr <= $signed(thrWrData);
    end
  end

  logic cntHit;
  logic sumHit;
  logic fleeNow;
  assign cntHit  = (negNow >= cntThr);
  assign sumHit  = (sumNow < sumThr);
  assign fleeNow = strobe.useSum ? sumHit : cntHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fleeQ     <= 1'b0;
      negCountQ <= '0;
      sumQ      <= '0;
      badQ      <= 1'b0;
    end else if (strobe.capture) begin
      fleeQ     <= fleeNow;
      negCountQ <= negNow;
      sumQ      <= sumNow;
      badQ      <= |isBad;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable({fleeQ, negCountQ, sumQ, badQ})); // R7
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    negCountQ <= CNT_W'(NUM_TRITS)); // R3
  AST_SUM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sumQ >= -$signed({1'b0, negCountQ})); // R4
  AST_SUM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $signed({1'b0, negCountQ}) + $signed({1'b0, negCountQ}) + sumQ
      <= $signed(SUM_W'(NUM_TRITS))); // R4
  AST_CNT_THR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCnt |=> $stable(cntThr)); // R8
  AST_SUM_THR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadSum |=> $stable(sumThr)); // R8

endmodule

// File: rtl/trit_flee_detector.sv
module trit_flee_detector
  import trit_flee_pkg::*;
#(
  parameter int NUM_TRITS   = 9,
  parameter int CNT_W       = $clog2(NUM_TRITS + 1),
  parameter int SUM_W       = CNT_W + 1,
  parameter int CNT_THR_RST = 7,
  parameter int SUM_THR_RST = -5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic [2*NUM_TRITS-1:0] sampleTrits,
  input  logic                   modeSum,
  input  logic                   thrWrEn,
  input  logic                   thrWrSel,
  input  logic [SUM_W-1:0]       thrWrData,
  output logic                   fleeValid,
  output logic                   flee,
  output logic [CNT_W-1:0]       negCount,
  output logic [SUM_W-1:0]       trSum,
  output logic                   badCode
);

  flee_strobe_t            strobe;
  logic signed [SUM_W-1:0] sumQ;

  trit_flee_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .modeSum     (modeSum),
    .thrWrEn     (thrWrEn),
    .thrWrSel    (thrWrSel),
    .strobe      (strobe),
    .outValid    (fleeValid)
  );

  trit_flee_dp #(
    .NUM_TRITS   (NUM_TRITS),
    .CNT_W       (CNT_W),
    .SUM_W       (SUM_W),
    .CNT_THR_RST (CNT_THR_RST),
    .SUM_THR_RST (SUM_THR_RST)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleTrits (sampleTrits),
    .thrWrData   (thrWrData),
    .fleeQ       (flee),
    .negCountQ   (negCount),
    .sumQ        (sumQ),
    .badQ        (badCode)
  );

  assign trSum = sumQ;

endmodule

// File: tb/trit_flee_detector_tb_top.sv
module trit_flee_detector_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [17:0] sampleTrits = '0;
  logic        modeSum = 1'b0;
  logic        thrWrEn = 1'b0;
  logic        thrWrSel = 1'b0;
  logic [4:0]  thrWrData = '0;
  logic        fleeValid;
  logic        flee;
  logic [3:0]  negCount;
  logic [4:0]  trSum;
  logic        badCode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trit_flee_detector dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTrits(sampleTrits),
    .modeSum(modeSum), .thrWrEn(thrWrEn), .thrWrSel(thrWrSel), .thrWrData(thrWrData),
    .fleeValid(fleeValid), .flee(flee), .negCount(negCount), .trSum(trSum),
    .badCode(badCode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input int v);
    return (v < 0) ? 2'b11 : (v > 0) ? 2'b01 : 2'b00;
  endfunction

  // Build a vector with nNeg symbols at -1 and nPos at +1, rest 0
  function automatic logic [17:0] mix(input int nNeg, input int nPos);
    logic [17:0] v = '0;
    for (int k = 0; k < 9; k++) begin
      if (k < nNeg) v[2*k +: 2] = 2'b11;
      else if (k < nNeg + nPos) v[2*k +: 2] = 2'b01;
    end
    return v;
  endfunction

  // Sample on one edge, result visible after it; one idle cycle follows
  task automatic doSample(input logic [17:0] t, input logic m);
    @(negedge clk);
    sampleTrits = t; modeSum = m; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    chk(fleeValid == 1'b1, "R7 valid", int'(fleeValid), 1);
  endtask

  task automatic wrThr(input logic sel, input logic [4:0] d);
    @(negedge clk);
    thrWrEn = 1'b1; thrWrSel = sel; thrWrData = d;
    @(negedge clk);
    thrWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk({fleeValid, flee, negCount, trSum, badCode} == '0, "R10 reset",
        int'({fleeValid, flee, negCount, trSum, badCode}), 0);

    // R1 R3 R4 R5 R6: every legal pattern, both rules, default limits
    for (int p = 0; p < 19683; p++) begin
      logic [17:0] v;
      int q, nn, s;
      q = p; nn = 0; s = 0; v = '0;
      for (int k = 0; k < 9; k++) begin
        int d, val;
        d = q % 3; q = q / 3;
        val = (d == 0) ? 0 : (d == 1) ? 1 : -1;
        v[2*k +: 2] = enc(val);
        if (val < 0) nn++;
        s += val;
      end
      doSample(v, 1'b0);
      chk(int'(negCount) == nn, "R3 count", int'(negCount), nn);
      chk(int'($signed(trSum)) == s, "R4 sum", int'($signed(trSum)), s);
      chk(badCode == 1'b0, "R1 legal", int'(badCode), 0);
      chk(flee == (nn >= 7), "R5 count rule", int'(flee), int'(nn >= 7));
      doSample(v, 1'b1);
      chk(flee == (s < -5), "R6 sum rule", int'(flee), int'(s < -5));
    end

    // R2 illegal codes
    doSample({9{2'b10}}, 1'b0);
    chk(badCode == 1'b1, "R2 flag", int'(badCode), 1);
    chk(negCount == 4'd0 && trSum == 5'd0, "R2 as zero", int'(negCount), 0);
    doSample({2'b10, {8{2'b11}}}, 1'b0);
    chk(int'(negCount) == 8 && flee, "R2 mixed count", int'(negCount), 8);
    chk(badCode == 1'b1, "R2 mixed flag", int'(badCode), 1);
    doSample({{3{2'b10}}, {6{2'b11}}}, 1'b1);
    chk(int'($signed(trSum)) == -6 && flee, "R2 sum", int'($signed(trSum)), -6);
    doSample(mix(0, 0), 1'b0);
    chk(badCode == 1'b0, "R2 flag clears", int'(badCode), 0);

    // R7 hold while idle, R9 mode change after result
    doSample(mix(7, 0), 1'b0);
    @(negedge clk); modeSum = 1'b1;
    @(negedge clk);
    chk(fleeValid == 1'b0, "R7 single pulse", int'(fleeValid), 0);
    chk(flee == 1'b1 && int'(negCount) == 7, "R9 mode change no effect", int'(flee), 1);
    modeSum = 1'b0;

    // R8 same-edge write uses old threshold
    @(negedge clk);
    sampleTrits = mix(5, 0); modeSum = 1'b0; sampleValid = 1'b1;
    thrWrEn = 1'b1; thrWrSel = 1'b0; thrWrData = 5'd5;
    @(negedge clk);
    sampleValid = 1'b0; thrWrEn = 1'b0;
    chk(flee == 1'b0, "R8 same edge old", int'(flee), 0);
    doSample(mix(5, 0), 1'b0);
    chk(flee == 1'b1, "R8 new threshold", int'(flee), 1);

    // R8 count threshold sweep, bit 4 ignored
    for (int t = 0; t <= 9; t++) begin
      wrThr(1'b0, {1'b1, 4'(t)});
      for (int c = 0; c <= 9; c++) begin
        doSample(mix(c, 0), 1'b0);
        chk(flee == (c >= t), "R8 count sweep", int'(flee), int'(c >= t));
      end
    end

    // R8 sum bound sweep
    for (int b = -9; b <= 9; b++) begin
      wrThr(1'b1, 5'(b));
      for (int s = -9; s <= 9; s++) begin
        doSample((s < 0) ? mix(-s, 0) : mix(0, s), 1'b1);
        chk(flee == (s < b), "R8 sum sweep", int'(flee), int'(s < b));
      end
    end

    // Sum bound write leaves count threshold alone (last set 9)
    doSample(mix(8, 0), 1'b0);
    chk(flee == 1'b0, "R8 select count kept", int'(flee), 0);

    // R10 reset restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk(fleeValid == 1'b0 && flee == 1'b0, "R10 reset again", int'(flee), 0);
    doSample(mix(7, 0), 1'b0);
    chk(flee == 1'b1, "R5 default 7", int'(flee), 1);
    doSample(mix(6, 0), 1'b0);
    chk(flee == 1'b0, "R5 below 7", int'(flee), 0);
    doSample(mix(6, 1), 1'b1);
    chk(flee == 1'b0, "R6 sum -5 not below", int'(flee), 0);
    doSample(mix(6, 0), 1'b1);
    chk(flee == 1'b1, "R6 sum -6", int'(flee), 1);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule